// File: doc/BRIEF.md
# Two-Wire Line Control Register

A small memory-mapped slave that lets software drive the clock and data lines of a two-wire serial bus by hand. The block performs no protocol work itself: software raises and lowers each line through register writes and samples the data line through a register read, and so generates start, stop, data and acknowledge timing entirely in software.

Each line is modelled by one state bit. A 1 releases the line (it floats high through its external pull-up) and a 0 pulls it low. Because the pads are open-drain, the block only ever drives a 0 and uses the output enable to choose between pulling low and releasing. Line levels change only through two separate addresses: one that can only release lines and one that can only pull them low. That way a single write never touches a line it does not name. The readback word combines the driven clock state with the data line level sensed at the pad, after that level passes through a synchroniser.

The bus side is a plain register port with address, write strobe, write data, read strobe and registered read data. It decodes a 4 KiB byte window.

Top module: `twl_pinctl`

## Requirements
- R1: In the cycle after synchronous reset, both line state bits are 1, both output enables are low, and the read data port is 0.
- R2: A write to byte offset 0x0 ORs write-data bits [1:0] into the line state. Bit 0 is the clock line and bit 1 the data line. Write-data bits above bit 1 have no effect. The new state appears at the pins one clock after the write strobe.
- R3: A write to byte offset 0x4 clears every line state bit whose write-data bit is 1. Bit 0 is the clock line and bit 1 the data line. It leaves bits whose write-data bit is 0 unchanged.
- R4: A write to any offset other than 0x0 and 0x4 leaves both line state bits unchanged.
- R5: Each pad is open-drain. Its output value is always 0, and its output enable is high exactly when the line's state bit is 0.
- R6: A read strobe at offset 0x0 loads the read data port, one clock later, with a word that has the clock state bit in bit 0, the synchronised data-line level in bit 1, and zeros in bits above 1.
- R7: A read strobe at any offset other than 0x0 loads the read data port with all ones one clock later.
- R8: The data line input passes through two flip-flops before the read path. A read strobe issued in the same cycle as a level change, or one cycle after it, still returns the old level. A read strobe issued two cycles after the change returns the new level.
- R9: The read data port holds its last value in every cycle without a read strobe, including cycles with writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| scl_o | output | 1 | Clock pad output value (always 0) |
| scl_oe | output | 1 | Clock pad output enable, high pulls the line low |
| sda_o | output | 1 | Data pad output value (always 0) |
| sda_oe | output | 1 | Data pad output enable, high pulls the line low |
| sda_i | input | 1 | Data pad input level |

## Verification
The hardest case to reach from the ports is the synchroniser lag: a read that lands within two cycles of a data-line change must still see the old level. The bench drives that case by flipping the external data level and issuing three read strobes back to back in the same and following cycles, and expects old, old, then new. It also models the pad as wired-AND, so that pulling the data line low through the clear register shows up in the sensed bit. That exercises the path from the driven state through the pad to the readback.

// File: rtl/twl_pkg.sv
package twl_pkg;
  localparam int unsigned OFF_SET   = 'h0;
  localparam int unsigned OFF_CLR   = 'h4;
  localparam int unsigned LINE_SCL  = 0;
  localparam int unsigned LINE_SDA  = 1;
  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/twl_sync.sv
module twl_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else     chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/twl_lines.sv
module twl_lines #(
  parameter int unsigned LINES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [LINES-1:0] mask,
  output logic [LINES-1:0] state,
  output logic [LINES-1:0] pad_o,
  output logic [LINES-1:0] pad_oe
);
  always_ff @(posedge clk) begin
    if (rst)         state <= '1;
    else if (set_en) state <= state | mask;
    else if (clr_en) state <= state & ~mask;
  end

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_pad
      assign pad_o[i]  = 1'b0;
      assign pad_oe[i] = ~state[i];
    end
  endgenerate
endmodule

// File: rtl/twl_readback.sv
module twl_readback #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic              hit,
  input  logic              scl_state,
  input  logic              sda_level,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word    = '0;
    word[0] = scl_state;
    word[1] = sda_level;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= hit ? word : '1;
  end
endmodule

// File: rtl/twl_pinctl.sv
module twl_pinctl
  import twl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              scl_o,
  output logic              scl_oe,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic              sda_i
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_CLR);

  logic                 hit_set, hit_clr;
  logic [NUM_LINES-1:0] state, pad_o, pad_oe;
  logic                 sda_sync;
  logic                 unused_wdata;

  assign hit_set      = (bus_addr == A_SET);
  assign hit_clr      = (bus_addr == A_CLR);
  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_LINES];

  twl_lines #(.LINES(NUM_LINES)) u_lines (
    .clk    (clk),
    .rst    (rst),
    .set_en (bus_wr & hit_set),
    .clr_en (bus_wr & hit_clr),
    .mask   (bus_wdata[NUM_LINES-1:0]),
    .state  (state),
    .pad_o  (pad_o),
    .pad_oe (pad_oe)
  );

  twl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sda_i),
    .q   (sda_sync)
  );

  twl_readback #(.DATA_W(DATA_W)) u_rb (
    .clk       (clk),
    .rst       (rst),
    .rd        (bus_rd),
    .hit       (hit_set),
    .scl_state (state[LINE_SCL]),
    .sda_level (sda_sync),
    .rdata     (bus_rdata)
  );

  assign scl_o  = pad_o[LINE_SCL];
  assign scl_oe = pad_oe[LINE_SCL];
  assign sda_o  = pad_o[LINE_SDA];
  assign sda_oe = pad_oe[LINE_SDA];
endmodule

// File: rtl/twl_pinctl_chk.sv
module twl_pinctl_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [1:0]        wbits,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              scl_o,
  input logic              scl_oe,
  input logic              sda_o,
  input logic              sda_oe
);
  logic at_set, at_clr;
  assign at_set = (bus_addr == ADDR_W'(4'h0));
  assign at_clr = (bus_addr == ADDR_W'(4'h4));

  a_r2_set_scl: assert property (@(posedge clk) disable iff (rst)
    bus_wr && at_set && wbits[0] |=> !scl_oe);
  a_r2_set_sda: assert property (@(posedge clk) disable iff (rst)
    bus_wr && at_set && wbits[1] |=> !sda_oe);
  a_r3_clr_scl: assert property (@(posedge clk) disable iff (rst)
    bus_wr && at_clr && wbits[0] |=> scl_oe);
  a_r3_clr_sda: assert property (@(posedge clk) disable iff (rst)
    bus_wr && at_clr && wbits[1] |=> sda_oe);
  a_r4_no_change: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (at_set || at_clr)) |=> $stable(scl_oe) && $stable(sda_oe));
  a_r5_open_drain: assert property (@(posedge clk) disable iff (rst)
    !scl_o && !sda_o);
  a_r6_read_word: assert property (@(posedge clk) disable iff (rst)
    bus_rd && at_set |=> bus_rdata[DATA_W-1:2] == '0 && bus_rdata[0] == !$past(scl_oe));
  a_r7_bad_read: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !at_set |=> bus_rdata == '1);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind twl_pinctl twl_pinctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .wbits     (bus_wdata[1:0]),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .scl_o     (scl_o),
  .scl_oe    (scl_oe),
  .sda_o     (sda_o),
  .sda_oe    (sda_oe)
);

// File: tb/sim_twl_pinctl.sv
`timescale 1ns/1ps
module sim_twl_pinctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        scl_o, scl_oe, sda_o, sda_oe, sda_i;
  logic        ext_sda = 1'b1;

  int checks = 0;
  int fails  = 0;
  logic [1:0] st = 2'b11;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_rd = '0;

  always #5 clk = ~clk;

  // wired-AND pad: the line is low if the block pulls or the far side holds it low
  assign sda_i = ext_sda & ~sda_oe;

  twl_pinctl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .scl_o(scl_o), .scl_oe(scl_oe), .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares the registered read data one clock after each strobe
  always @(posedge clk) rd_seen <= bus_rd && !rst;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
      last_rd = e;
    end
  end

  task automatic pins(string req);
    check({req, " scl_oe"}, {31'b0, scl_oe}, {31'b0, ~st[0]});
    check({req, " sda_oe"}, {31'b0, sda_oe}, {31'b0, ~st[1]});
    check("R5 pad values", {30'b0, scl_o, sda_o}, 32'h0);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string req);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 12'h0)      st = st | d[1:0];
    else if (a == 12'h4) st = st & ~d[1:0];
    pins(req);
  endtask

  // driver: pushes the expected word, then issues the strobe
  task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] word();
    return {30'b0, ext_sda & st[1], st[0]};
  endfunction

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 oe", {30'b0, scl_oe, sda_oe}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(12'h0, 32'h3, "R6 read after reset");

    wr(12'h4, 32'h1, "R3 clear scl");
    rd(12'h0, word(), "R6 scl low");
    wr(12'h4, 32'h2, "R3 clear sda");
    idle(3);
    rd(12'h0, word(), "R6 sda pulled low sensed");
    wr(12'h0, 32'hFFFF_FFFD, "R2 set scl, high bits ignored");
    idle(3);
    rd(12'h0, word(), "R2 readback after set");
    wr(12'h0, 32'h2, "R2 set sda");
    idle(3);
    rd(12'h0, word(), "R6 both released");

    wr(12'h4, 32'h3, "R3 clear both");
    wr(12'h8, 32'h3, "R4 write 0x8 ignored");
    wr(12'hFFC, 32'h3, "R4 write 0xFFC ignored");
    wr(12'h1, 32'h3, "R4 write 0x1 ignored");
    wr(12'h0, 32'h3, "R2 set both");
    idle(3);

    rd(12'h8, 32'hFFFF_FFFF, "R7 read 0x8");
    rd(12'h4, 32'hFFFF_FFFF, "R7 read 0x4");
    rd(12'hFFC, 32'hFFFF_FFFF, "R7 read 0xFFC");

    // R8: change the line, then three back-to-back strobes
    ext_sda = 1'b0;
    rd(12'h0, 32'h3, "R8 same cycle old level");
    rd(12'h0, 32'h3, "R8 one cycle later old level");
    rd(12'h0, 32'h1, "R8 two cycles later new level");
    ext_sda = 1'b1;
    idle(3);
    rd(12'h0, 32'h3, "R8 line back high");

    // R9 hold without strobes, including during writes
    idle(3);
    check("R9 hold idle", bus_rdata, last_rd);
    wr(12'h4, 32'h1, "R3 clear scl again");
    idle(2);
    check("R9 hold across write", bus_rdata, last_rd);
    wr(12'h0, 32'h1, "R2 restore scl");

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule